// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Counter

This block keeps a running count that estimates how much charge a stored battery pack loses on its own. It takes a slow base tick (eight ticks per hour in the intended system) and a quantized temperature band from an external sensor. It divides the tick by a power of two chosen from the band, and each divided tick adds one to a saturating count register. At nominal room temperature the count rises by one per hour. Each 10 °C step warmer doubles the rate and each 10 °C step cooler halves it, and the rate is clamped at both ends of the band table.

The host reads the count and is the only agent that clears it. A suspend input freezes all counting while the pack sleeps. When the temperature band changes between ticks, the ticks already collected are kept, so no elapsed time is lost or counted twice.

Top module: `sdc_selfdis_counter`

## Requirements
- R1: After reset the count reads 0 and the prescaler is empty, so in band 3 the first increment comes on exactly the 8th counted tick.
- R2: Band codes 0 to 6 stand for <5, 5–15, 15–25, 25–35, 35–45, 45–55 and ≥55 °C. A counted tick advances the count after 64, 32, 16, 8, 4, 2 and 1 ticks respectively, which is 1/8 to 8 counts per hour at 8 ticks per hour.
- R3: The count saturates at all ones and stays there on further ticks.
- R4: Band codes above 6 use the band 6 rate (one increment per counted tick).
- R5: While suspend is high, ticks are ignored: neither the count nor the collected prescaler ticks change.
- R6: A host clear sets the count and the prescaler to zero on the next edge. It wins over a tick in the same cycle and also acts while suspended.
- R7: On a band change the collected tick count is kept and only the reload limit changes. If the collected ticks already reach the new limit, the next counted tick increments.
- R8: Without a tick or a clear, the count holds its value.
- R9: Apart from a clear, the count changes by at most +1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle base time tick (8 per hour) |
| temp_band | input | BAND_W | Quantized temperature band code |
| suspend | input | 1 | High: counting suspended |
| host_clr | input | 1 | One-cycle clear strobe from the host |
| sd_count | output | CNT_W | Self-discharge count |

## Verification
The bench builds the block with a 10-bit count and keeps the default seven bands with the 3-bit band code. The narrow count lets saturation at all ones be reached with about a thousand fast-band ticks inside the cycle limit. The full band table, including the clamped code 7, stays in use. Every band is run for two full reload periods. Band changes are made with ticks already collected, to show that the remainder is kept.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   // Ticks needed per increment for a band index: 2^(top - band)
   function automatic int unsigned ticks_per_inc(input int unsigned band,
                                                 input int unsigned num_bands);
      return 32'd1 << (num_bands - 1 - band);
   endfunction
endpackage

// File: rtl/sdc_band_map.sv
module sdc_band_map #(
   parameter int BAND_W    = 3,
   parameter int NUM_BANDS = 7,
   localparam int PRE_W    = NUM_BANDS - 1
) (
   input  logic [BAND_W-1:0] band_code,
   output logic [PRE_W:0]    reload
);
   localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NUM_BANDS - 1);

   logic [PRE_W:0]      limit_tbl [NUM_BANDS];
   logic [BAND_W-1:0]   band_clamped;

   // Build the reload table from the band index
   for (genvar g = 0; g < NUM_BANDS; g++) begin : g_tbl
      assign limit_tbl[g] = (PRE_W+1)'(sdc_pkg::ticks_per_inc(g, NUM_BANDS));
   end

   // Out-of-range codes fall back to the fastest band
   always_comb begin
      if (band_code > TOP_BAND) band_clamped = TOP_BAND;
      else                      band_clamped = band_code;
   end

   assign reload = limit_tbl[band_clamped];
endmodule

// File: rtl/sdc_prescaler.sv
module sdc_prescaler #(
   parameter int PRE_W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         clear,
   input  logic [PRE_W:0] reload,
   output logic         fire
);
   logic [PRE_W-1:0] elapsed_q;
   logic [PRE_W:0]   elapsed_next;

   assign elapsed_next = {1'b0, elapsed_q} + 1'b1;
   assign fire         = advance && !clear && (elapsed_next >= reload);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         elapsed_q <= '0;
      end else if (advance) begin
         if (fire) elapsed_q <= '0;
         else      elapsed_q <= elapsed_next[PRE_W-1:0];
      end
   end
endmodule

// File: rtl/sdc_sat_counter.sv
module sdc_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [CNT_W-1:0] value_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         value_q <= '0;
      end else if (inc && (value_q != FULL)) begin
         value_q <= value_q + 1'b1;
      end
   end

   assign value = value_q;
endmodule

// File: rtl/sdc_selfdis_counter.sv
module sdc_selfdis_counter #(
   parameter int CNT_W     = 16,
   parameter int BAND_W    = 3,
   parameter int NUM_BANDS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic [BAND_W-1:0] temp_band,
   input  logic              suspend,
   input  logic              host_clr,
   output logic [CNT_W-1:0]  sd_count
);
   localparam int PRE_W = NUM_BANDS - 1;

   if (NUM_BANDS < 2) begin : g_bad_bands
      $error("NUM_BANDS must be at least 2");
   end
   if (NUM_BANDS > (1 << BAND_W)) begin : g_bad_code
      $error("BAND_W too narrow for NUM_BANDS");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [PRE_W:0] reload;
   logic           counted_tick;
   logic           pre_fire;

   assign counted_tick = base_tick && !suspend;

   sdc_band_map #(.BAND_W(BAND_W), .NUM_BANDS(NUM_BANDS)) u_map (
      .band_code (temp_band),
      .reload    (reload)
   );

   sdc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (counted_tick),
      .clear   (host_clr),
      .reload  (reload),
      .fire    (pre_fire)
   );

   sdc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (host_clr),
      .inc   (pre_fire),
      .value (sd_count)
   );
endmodule

// File: rtl/sdc_selfdis_checker.sv
module sdc_selfdis_checker #(
   parameter int CNT_W     = 16,
   parameter int BAND_W    = 3,
   parameter int NUM_BANDS = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              base_tick,
   input logic [BAND_W-1:0] temp_band,
   input logic              suspend,
   input logic              host_clr,
   input logic [CNT_W-1:0]  sd_count
);
   localparam logic [CNT_W-1:0]  FULL     = '1;
   localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NUM_BANDS - 1);

   p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_count == FULL && !host_clr) |=> (sd_count == FULL));

   p_fast_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (base_tick && !suspend && !host_clr && temp_band >= TOP_BAND && sd_count != FULL)
      |=> (sd_count == CNT_W'($past(sd_count) + 1'b1)));

   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend && !host_clr) |=> $stable(sd_count));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (sd_count == '0));

   p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!base_tick && !host_clr) |=> $stable(sd_count));

   p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_clr |=> (sd_count == $past(sd_count) ||
                     sd_count == CNT_W'($past(sd_count) + 1'b1)));
endmodule

bind sdc_selfdis_counter sdc_selfdis_checker #(
   .CNT_W(CNT_W), .BAND_W(BAND_W), .NUM_BANDS(NUM_BANDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .base_tick (base_tick),
   .temp_band (temp_band),
   .suspend   (suspend),
   .host_clr  (host_clr),
   .sd_count  (sd_count)
);

// File: tb/tb_sdc_selfdis_counter.sv
module tb_sdc_selfdis_counter;
   localparam int CNT_W  = 10;
   localparam int BAND_W = 3;
   localparam int NB     = 7;
   localparam int FULL   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              base_tick = 1'b0;
   logic [BAND_W-1:0] temp_band = '0;
   logic              suspend = 1'b0;
   logic              host_clr = 1'b0;
   logic [CNT_W-1:0]  sd_count;

   int checks = 0;
   int errors = 0;
   int m_pre  = 0;
   int m_cnt  = 0;
   bit done   = 1'b0;

   int    exp_q [$];
   string tag_q [$];

   always #5 clk = ~clk;

   sdc_selfdis_counter #(.CNT_W(CNT_W), .BAND_W(BAND_W), .NUM_BANDS(NB)) dut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .temp_band(temp_band),
      .suspend(suspend), .host_clr(host_clr), .sd_count(sd_count)
   );

   task automatic check(input int got, input int exp, input string tag);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: sd_count=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected count
   task automatic step(input bit t, input int b, input bit s, input bit c,
                       input string tag);
      int eff;
      int lim;
      @(negedge clk);
      base_tick = t;
      temp_band = BAND_W'(b);
      suspend   = s;
      host_clr  = c;
      eff = (b > NB - 1) ? NB - 1 : b;
      lim = 1 << (NB - 1 - eff);
      if (c) begin
         m_cnt = 0;
         m_pre = 0;
      end else if (t && !s) begin
         if (m_pre + 1 >= lim) begin
            m_pre = 0;
            if (m_cnt < FULL) m_cnt++;
         end else begin
            m_pre++;
         end
      end
      exp_q.push_back(m_cnt);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            int e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(int'(sd_count), e, tg);
         end
      end
   end

   initial begin
      #1_500_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(int'(sd_count), 0, "R1 reset value");

      // R1: band 3 needs exactly 8 ticks for the first increment
      for (int i = 0; i < 8; i++) step(1, 3, 0, 0, "R1");

      // R2 and R8: each band over two reload periods, with idle cycles between
      for (int b = 0; b < NB; b++) begin
         step(0, b, 0, 1, "R6");
         for (int i = 0; i < 2 * (1 << (NB - 1 - b)); i++) begin
            step(1, b, 0, 0, "R2");
            step(0, b, 0, 0, "R8");
         end
      end

      // R4: code 7 counts like band 6
      step(0, 7, 0, 1, "R6");
      for (int i = 0; i < 5; i++) step(1, 7, 0, 0, "R4");

      // R5: ticks during suspend are ignored, prescaler keeps its remainder
      step(0, 3, 0, 1, "R6");
      for (int i = 0; i < 5; i++) step(1, 3, 0, 0, "R5");
      for (int i = 0; i < 6; i++) step(1, 3, 1, 0, "R5");
      for (int i = 0; i < 3; i++) step(1, 3, 0, 0, "R5");

      // R6: clear beats a same-cycle tick; clear works while suspended
      for (int i = 0; i < 4; i++) step(1, 6, 0, 0, "R4");
      step(1, 6, 0, 1, "R6");
      step(1, 6, 0, 0, "R6");
      step(0, 6, 1, 1, "R6");
      step(1, 6, 0, 0, "R6");
      step(0, 6, 0, 1, "R6");

      // R7: band change keeps collected ticks
      for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R7");
      step(1, 3, 0, 0, "R7");
      for (int i = 0; i < 3; i++) step(1, 2, 0, 0, "R7");
      for (int i = 0; i < 14; i++) step(1, 2, 0, 0, "R7");

      // R3 and R9: run the fast band into saturation
      step(0, 6, 0, 1, "R6");
      for (int i = 0; i < FULL + 8; i++) step(1, 6, 0, 0, "R3");
      step(0, 6, 0, 0, "R9");

      @(negedge clk);
      base_tick = 1'b0;
      host_clr  = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule